// File: doc/BRIEF.md
# Serial Segment-Display Command Front End

This block is the host-facing input stage of a small segment LCD controller. A host sends bytes over a four-wire serial link: an active-low select, a serial clock, a data line and a line that tells data from command. All four inputs are brought into the block's system clock domain through synchronizer stages, and the serial clock's rising edges are found by edge detection. Each complete byte is then either run as a command or stored in the display memory.

Command bytes update a set of display flags: display enable, inverted display, all segments lit and mirrored segment order. They also load the column pointer, which is set in two parts, a 3-bit upper field and a 4-bit lower field. Data bytes store their low nibble into a 96-column by 4-row display memory at the column pointer, and the pointer then advances. A scanning back end reads the memory through a combinational read port and takes the flags straight from the outputs. A power-save flag is derived from the display enable and all-segments-lit flags.

Top module: `lcd_cmd_front`

## Requirements
- R1: Serial bits are taken most significant bit first on each rising `spi_sclk` edge while `spi_cs_n` is low. The value of `spi_dc` at the eighth bit classifies the byte: 1 is display data, 0 is a command. A data byte never changes any flag.
- R2: While `spi_cs_n` is high, the bit counter and the partial byte are cleared. A byte cut short by a rise of `spi_cs_n` is dropped, and the next select window starts a fresh byte.
- R3: Command 0x29 sets `disp_on` and command 0x28 clears it. `disp_on` changes only in the cycle after a command byte.
- R4: Commands 0x2B and 0x2A set and clear `disp_inverse`. Commands 0x2F and 0x2E set and clear `seg_flip`. `seg_flip` changes only in the cycle after a command byte.
- R5: Command 0x2D sets `all_on` and command 0x2C clears it.
- R6: Command 0x2D given while `disp_on` is 0 sets `power_save`. Command 0x2C or command 0x29 clears it. Command 0x28 alone never sets it. `power_save` high implies `disp_on` low and `all_on` high.
- R7: After `rst_n` low, `disp_on`=0, `all_on`=1, `power_save`=1, `disp_inverse`=0, `seg_flip`=0, the column pointer is 0 and every memory column reads 0. Command 0x3F restores the same flags and column pointer 0 and leaves the memory contents unchanged.
- R8: Command 0b00010uuu loads column pointer bits 6:4 with uuu. Command 0b0000llll loads bits 3:0 with llll. A data byte stores its bits 3:0 at the pointed column, and bits 7:4 are ignored.
- R9: Each data write advances the column pointer by one. A write to column 95 wraps the pointer to 0.
- R10: If the pointer holds a value above 95 when a data byte arrives, the byte is stored at column 0 and the pointer moves to 1.
- R11: Command bytes with no assigned meaning change neither the flags nor the column pointer.
- R12: `rd_bits` returns the 4 bits of column `rd_col`, or 0 when `rd_col` is above 95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock, sampled on rising edge |
| spi_sdi | input | 1 | Serial data, MSB first |
| spi_dc | input | 1 | 1 = display data byte, 0 = command byte |
| rd_col | input | 7 | Memory read column from the scanner |
| rd_bits | output | 4 | Row bits of column rd_col |
| disp_on | output | 1 | Display enabled |
| disp_inverse | output | 1 | Inverted display |
| all_on | output | 1 | All segments forced on |
| seg_flip | output | 1 | Segment order mirrored |
| power_save | output | 1 | Power-save state |

## Verification
A corrupted column pointer is not visible at the flags. It shows up only at the memory read port, on the next data byte, as a nibble stored in the wrong column. For that reason every pointer scenario writes at least two bytes and reads back the columns on both sides of the expected location. A fault in the byte framer appears one full byte later, either as a flag that fails to toggle or as bit-reversed data. A fault in the power-save bookkeeping appears in the cycle after the relevant command.

// File: rtl/lcd_cmd_front_pkg.sv
package lcd_cmd_front_pkg;

   // column pointer width fixed by the split 3+4 bit column-set commands
   localparam int PTR_W = 7;

   localparam logic [7:0] OPC_DISP_OFF = 8'h28;
   localparam logic [7:0] OPC_DISP_ON  = 8'h29;
   localparam logic [7:0] OPC_INV_OFF  = 8'h2A;
   localparam logic [7:0] OPC_INV_ON   = 8'h2B;
   localparam logic [7:0] OPC_ALL_OFF  = 8'h2C;
   localparam logic [7:0] OPC_ALL_ON   = 8'h2D;
   localparam logic [7:0] OPC_SEG_NORM = 8'h2E;
   localparam logic [7:0] OPC_SEG_FLIP = 8'h2F;
   localparam logic [7:0] OPC_SOFT_RST = 8'h3F;
   localparam logic [4:0] OPC_COLHI_PFX = 5'b00010;
   localparam logic [3:0] OPC_COLLO_PFX = 4'b0000;

   typedef struct packed {
      logic disp_on;
      logic inverse;
      logic all_on;
      logic seg_flip;
      logic psave;
   } disp_flags_t;

   localparam disp_flags_t FLAGS_RST = '{disp_on: 1'b0, inverse: 1'b0,
                                        all_on: 1'b1, seg_flip: 1'b0,
                                        psave: 1'b1};

endpackage

// File: rtl/lcd_cmd_front_rx.sv
module lcd_cmd_front_rx #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       sdi,
   input  logic       dc,
   output logic       byte_vld,
   output logic [7:0] byte_q,
   output logic       byte_is_data
);

   localparam logic [3:0] SYNC_RST = 4'b1000;   // {cs_n, sclk, sdi, dc}

   logic [3:0] raw;
   logic [3:0] syn;
   assign raw = {cs_n, sclk, sdi, dc};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign syn = raw;
      end else begin : g_sync
         logic [3:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= SYNC_RST;
            else        stg[0] <= raw;
         end
         for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= SYNC_RST;
               else        stg[i] <= stg[i-1];
            end
         end
         assign syn = stg[SYNC_STAGES-1];
      end
   endgenerate

   logic       s_cs_n, s_sclk, s_sdi, s_dc;
   logic       sclk_q;
   logic [6:0] shreg;
   logic [2:0] bit_cnt;

   assign {s_cs_n, s_sclk, s_sdi, s_dc} = syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q       <= 1'b0;
         shreg        <= '0;
         bit_cnt      <= '0;
         byte_vld     <= 1'b0;
         byte_q       <= '0;
         byte_is_data <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         sclk_q   <= s_sclk;
         if (s_cs_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
         end else if (s_sclk && !sclk_q) begin
            shreg   <= {shreg[5:0], s_sdi};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_vld     <= 1'b1;
               byte_q       <= {shreg, s_sdi};
               byte_is_data <= s_dc;
            end
         end
      end
   end

endmodule

// File: rtl/lcd_cmd_front_dec.sv
module lcd_cmd_front_dec
   import lcd_cmd_front_pkg::*;
#(
   parameter int COLS = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [7:0]       byte_q,
   input  logic             byte_is_data,
   output disp_flags_t      flags,
   output logic [PTR_W-1:0] col_ptr,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_col
);

   localparam logic [PTR_W-1:0] LAST_COL = PTR_W'(COLS - 1);

   logic [PTR_W-1:0] tgt;

   always_comb begin
      tgt    = (col_ptr > LAST_COL) ? '0 : col_ptr;
      wr_en  = byte_vld && byte_is_data;
      wr_col = tgt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= FLAGS_RST;
         col_ptr <= '0;
      end else if (byte_vld && byte_is_data) begin
         col_ptr <= (tgt == LAST_COL) ? '0 : tgt + 1'b1;
      end else if (byte_vld) begin
         unique case (byte_q)
            OPC_SOFT_RST: begin
               flags   <= FLAGS_RST;
               col_ptr <= '0;
            end
            OPC_DISP_OFF: flags.disp_on <= 1'b0;
            OPC_DISP_ON: begin
               flags.disp_on <= 1'b1;
               flags.psave   <= 1'b0;
            end
            OPC_ALL_ON: begin
               flags.all_on <= 1'b1;
               if (!flags.disp_on) flags.psave <= 1'b1;
            end
            OPC_ALL_OFF: begin
               flags.all_on <= 1'b0;
               flags.psave  <= 1'b0;
            end
            OPC_INV_OFF:  flags.inverse  <= 1'b0;
            OPC_INV_ON:   flags.inverse  <= 1'b1;
            OPC_SEG_NORM: flags.seg_flip <= 1'b0;
            OPC_SEG_FLIP: flags.seg_flip <= 1'b1;
            default: begin
               if (byte_q[7:3] == OPC_COLHI_PFX)
                  col_ptr[6:4] <= byte_q[2:0];
               else if (byte_q[7:4] == OPC_COLLO_PFX)
                  col_ptr[3:0] <= byte_q[3:0];
            end
         endcase
      end
   end

endmodule

// File: rtl/lcd_cmd_front_ram.sv
module lcd_cmd_front_ram
   import lcd_cmd_front_pkg::*;
#(
   parameter int COLS = 96,
   parameter int ROWS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_col,
   input  logic [ROWS-1:0]  wr_bits,
   input  logic [PTR_W-1:0] rd_col,
   output logic [ROWS-1:0]  rd_bits
);

   logic [ROWS-1:0] mem [COLS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < COLS; i++) mem[i] <= '0;
      end else if (wr_en && (int'(wr_col) < COLS)) begin
         mem[wr_col] <= wr_bits;
      end
   end

   assign rd_bits = (int'(rd_col) < COLS) ? mem[rd_col] : '0;

endmodule

// File: rtl/lcd_cmd_front.sv
module lcd_cmd_front
   import lcd_cmd_front_pkg::*;
#(
   parameter int COLS        = 96,
   parameter int ROWS        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spi_cs_n,
   input  logic            spi_sclk,
   input  logic            spi_sdi,
   input  logic            spi_dc,
   input  logic [6:0]      rd_col,
   output logic [ROWS-1:0] rd_bits,
   output logic            disp_on,
   output logic            disp_inverse,
   output logic            all_on,
   output logic            seg_flip,
   output logic            power_save
);

   generate
      if (COLS < 17 || COLS > (1 << PTR_W)) begin : g_bad_cols
         $error("COLS must lie between 17 and 128");
      end
      if (ROWS < 1 || ROWS > 8) begin : g_bad_rows
         $error("ROWS must lie between 1 and 8");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             byte_vld;
   logic [7:0]       byte_q;
   logic             byte_is_data;
   disp_flags_t      flags;
   logic [PTR_W-1:0] col_ptr;
   logic             wr_en;
   logic [PTR_W-1:0] wr_col;

   lcd_cmd_front_rx #(.SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk(clk), .rst_n(rst_n),
      .cs_n(spi_cs_n), .sclk(spi_sclk), .sdi(spi_sdi), .dc(spi_dc),
      .byte_vld(byte_vld), .byte_q(byte_q), .byte_is_data(byte_is_data)
   );

   lcd_cmd_front_dec #(.COLS(COLS)) dec_i (
      .clk(clk), .rst_n(rst_n),
      .byte_vld(byte_vld), .byte_q(byte_q), .byte_is_data(byte_is_data),
      .flags(flags), .col_ptr(col_ptr), .wr_en(wr_en), .wr_col(wr_col)
   );

   lcd_cmd_front_ram #(.COLS(COLS), .ROWS(ROWS)) ram_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_col(wr_col), .wr_bits(byte_q[ROWS-1:0]),
      .rd_col(rd_col), .rd_bits(rd_bits)
   );

   assign disp_on      = flags.disp_on;
   assign disp_inverse = flags.inverse;
   assign all_on       = flags.all_on;
   assign seg_flip     = flags.seg_flip;
   assign power_save   = flags.psave;

endmodule

// File: rtl/lcd_cmd_front_chk.sv
module lcd_cmd_front_chk #(
   parameter int COLS = 96,
   parameter int ROWS = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            byte_vld,
   input logic            byte_is_data,
   input logic            wr_en,
   input logic [6:0]      wr_col,
   input logic [6:0]      col_ptr,
   input logic [6:0]      rd_col,
   input logic [ROWS-1:0] rd_bits,
   input logic            disp_on,
   input logic            all_on,
   input logic            seg_flip,
   input logic            power_save
);

   localparam logic [6:0] LAST_COL = 7'(COLS - 1);

   // R3
   disp_cmd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(disp_on) |-> $past(byte_vld && !byte_is_data));

   // R4
   seg_cmd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seg_flip) |-> $past(byte_vld && !byte_is_data));

   // R6
   psave_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      power_save |-> (!disp_on && all_on));

   // R1
   data_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_is_data) |=> ($stable(disp_on) && $stable(all_on) && $stable(power_save)));

   // R9
   col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_col == LAST_COL) |=> (col_ptr == 7'd0));

   // R10
   wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_col <= LAST_COL));

   // R12
   rd_out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_col > LAST_COL) |-> (rd_bits == '0));

endmodule

bind lcd_cmd_front lcd_cmd_front_chk #(.COLS(COLS), .ROWS(ROWS)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .byte_vld(byte_vld), .byte_is_data(byte_is_data),
   .wr_en(wr_en), .wr_col(wr_col), .col_ptr(col_ptr),
   .rd_col(rd_col), .rd_bits(rd_bits),
   .disp_on(disp_on), .all_on(all_on), .seg_flip(seg_flip),
   .power_save(power_save)
);

// File: tb/lcd_cmd_front_tb_top.sv
`timescale 1ns/1ps
module lcd_cmd_front_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_sclk = 1'b0;
   logic       spi_sdi = 1'b0;
   logic       spi_dc = 1'b0;
   logic [6:0] rd_col = '0;
   logic [3:0] rd_bits;
   logic       disp_on, disp_inverse, all_on, seg_flip, power_save;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   lcd_cmd_front dut_i (
      .clk(clk), .rst_n(rst_n),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi), .spi_dc(spi_dc),
      .rd_col(rd_col), .rd_bits(rd_bits),
      .disp_on(disp_on), .disp_inverse(disp_inverse), .all_on(all_on),
      .seg_flip(seg_flip), .power_save(power_save)
   );

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_bits(input bit dc, input logic [7:0] b, input int nbits);
      @(negedge clk);
      spi_cs_n = 1'b0;
      spi_dc   = dc;
      wait_clk(4);
      for (int i = 7; i > 7 - nbits; i--) begin
         spi_sdi = b[i];
         wait_clk(4);
         spi_sclk = 1'b1;
         wait_clk(4);
         spi_sclk = 1'b0;
      end
      wait_clk(4);
      spi_cs_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic send_cmd(input logic [7:0] b);
      send_bits(1'b0, b, 8);
   endtask

   task automatic send_dat(input logic [7:0] b);
      send_bits(1'b1, b, 8);
   endtask

   task automatic read_col(input int c, output int v);
      @(negedge clk);
      rd_col = 7'(c);
      #1;
      v = int'(rd_bits);
   endtask

   task automatic check_flags(input string req, input int on, input int inv,
                              input int all, input int seg, input int ps);
      @(negedge clk);
      check({req, " disp_on"},      int'(disp_on), on);
      check({req, " disp_inverse"}, int'(disp_inverse), inv);
      check({req, " all_on"},       int'(all_on), all);
      check({req, " seg_flip"},     int'(seg_flip), seg);
      check({req, " power_save"},   int'(power_save), ps);
   endtask

   task automatic t_reset_state;
      int v;
      check_flags("R7 reset", 0, 0, 1, 0, 1);
      read_col(0, v);  check("R7 reset col0", v, 0);
      read_col(95, v); check("R7 reset col95", v, 0);
   endtask

   task automatic t_flags;
      send_cmd(8'h2C); check_flags("R5 all off", 0, 0, 0, 0, 0);
      send_cmd(8'h29); check_flags("R3 disp on", 1, 0, 0, 0, 0);
      send_cmd(8'h2B); check_flags("R4 inverse on", 1, 1, 0, 0, 0);
      send_cmd(8'h2F); check_flags("R4 seg flip", 1, 1, 0, 1, 0);
      send_cmd(8'h2A); check_flags("R4 inverse off", 1, 0, 0, 1, 0);
      send_cmd(8'h2E); check_flags("R4 seg normal", 1, 0, 0, 0, 0);
      send_cmd(8'h2D); check_flags("R5 all on while display on", 1, 0, 1, 0, 0);
      send_cmd(8'h28); check_flags("R6 display off alone", 0, 0, 1, 0, 0);
   endtask

   task automatic t_power_save;
      send_cmd(8'h2C); check_flags("R6 all off", 0, 0, 0, 0, 0);
      send_cmd(8'h2D); check_flags("R6 all on while off enters", 0, 0, 1, 0, 1);
      send_cmd(8'h2C); check_flags("R6 all off leaves", 0, 0, 0, 0, 0);
      send_cmd(8'h2D); check_flags("R6 reenter", 0, 0, 1, 0, 1);
      send_cmd(8'h29); check_flags("R6 display on leaves", 1, 0, 1, 0, 0);
   endtask

   task automatic t_write_incr;
      int v;
      send_cmd(8'h12); send_cmd(8'h03);       // column 35
      send_dat(8'hF6); send_dat(8'h09);
      read_col(34, v); check("R8 col34 untouched", v, 0);
      read_col(35, v); check("R8 high nibble ignored col35", v, 6);
      read_col(36, v); check("R9 increment col36", v, 9);
      read_col(37, v); check("R9 col37 untouched", v, 0);
   endtask

   task automatic t_wrap;
      int v;
      send_cmd(8'h15); send_cmd(8'h0F);       // column 95
      send_dat(8'h03); send_dat(8'h04);
      read_col(95, v); check("R9 col95", v, 3);
      read_col(0, v);  check("R9 wrap to col0", v, 4);
      read_col(94, v); check("R9 col94 untouched", v, 0);
   endtask

   task automatic t_clamp;
      int v;
      send_cmd(8'h17); send_cmd(8'h0F);       // column 127
      send_dat(8'h07); send_dat(8'h08);
      read_col(0, v); check("R10 clamp col0", v, 7);
      read_col(1, v); check("R10 next col1", v, 8);
   endtask

   task automatic t_unknown;
      int v;
      send_cmd(8'h10); send_cmd(8'h05);       // column 5
      send_cmd(8'h55); send_cmd(8'hFF); send_cmd(8'h20);
      check_flags("R11 flags kept", 1, 0, 1, 0, 0);
      send_dat(8'h0A);
      read_col(5, v); check("R11 pointer kept col5", v, 10);
      read_col(6, v); check("R11 col6 untouched", v, 0);
   endtask

   task automatic t_frame;
      int v;
      send_cmd(8'h10); send_cmd(8'h0A);       // column 10
      send_bits(1'b1, 8'hFF, 3);              // aborted by select rise
      send_dat(8'h05);
      read_col(10, v); check("R2 aborted byte dropped col10", v, 5);
      read_col(11, v); check("R2 col11 untouched", v, 0);
      send_dat(8'h0C);
      read_col(11, v); check("R1 MSB first col11", v, 12);
      send_dat(8'h28);                        // looks like display-off, sent as data
      check_flags("R1 data byte no flag change", 1, 0, 1, 0, 0);
      read_col(12, v); check("R1 data stored col12", v, 8);
   endtask

   task automatic t_read_range;
      int v;
      read_col(100, v); check("R12 read above 95", v, 0);
      read_col(127, v); check("R12 read 127", v, 0);
   endtask

   task automatic t_soft_reset;
      int v;
      send_cmd(8'h2F);
      send_cmd(8'h3F);
      check_flags("R7 reset command", 0, 0, 1, 0, 1);
      send_dat(8'h06);
      read_col(0, v);  check("R7 pointer back to col0", v, 6);
      read_col(35, v); check("R7 memory kept col35", v, 6);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset_state();
      t_flags();
      t_power_save();
      t_write_incr();
      t_wrap();
      t_clamp();
      t_unknown();
      t_frame();
      t_read_range();
      t_soft_reset();
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule